// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter (Master Mode)

This block drives a two-channel audio serial link as the clock master. It produces the bit clock, the frame clock and the serial data line. Each frame carries one left and one right sample, 16 bits each, sent most significant bit first. The frame clock runs in one of two framing styles. In level framing, the frame clock holds one level for the whole left half and the opposite level for the right half. In pulse framing, the frame clock gives a single one-bit-clock pulse at the start of each frame. Samples come in on a valid/ready stream, and the block takes one stereo word at every frame start.

The system clock enable `bit_tick` sets the pace. Each pulse moves the bit clock by one edge, so two pulses make one bit-clock period. Data and frame clock change only when the bit clock falls. Configuration inputs set five things: the number of bit clocks per channel minus one, an extra bit clock in the right half (non-symmetric frames), the data offset from the half start, the framing style and the polarity. These settings are captured at every frame start, so a change made in the middle of a frame applies from the next frame. When `tx_en` is dropped, the current frame runs to its end. The frame clock then rests at its idle level and the data line stays low.

The sequencer has three states. IDLE means the link is stopped. SLOT_L is the left half. SLOT_R is the right half. The transitions are:
- GO: IDLE to SLOT_L, on a falling edge with `tx_en` set.
- SWAP: SLOT_L to SLOT_R, after the last bit of the left half.
- NEXT: SLOT_R to SLOT_L, after the last bit with `tx_en` still set.
- STOP: SLOT_R to IDLE, after the last bit with `tx_en` clear.

Top module: `aud_ser_tx`

## Requirements
- R1: Reset state. After reset, `bclk` is 0, `sdata` is 0, `s_ready` is 0 and `urun` is 0. `fclk` is at its idle level. The idle level is `cfg_pol` in pulse framing (`cfg_fsync`=1) and the inverse of `cfg_pol` in level framing (`cfg_fsync`=0).
- R2: Bit clock. `bclk` toggles on every cycle where `bit_tick` is 1. `fclk` and `sdata` change only in the cycle where `bclk` falls.
- R3: Half lengths. The left half lasts `cfg_bitcnt`+1 bit clocks. The right half lasts `cfg_bitcnt`+1+`cfg_nonsym` bit clocks. Frames follow one another with no gap while `tx_en` stays 1.
- R4: Level framing (`cfg_fsync`=0). `fclk` equals `cfg_pol` through the left half and equals the inverse of `cfg_pol` through the right half. So with `cfg_pol`=0 the left sample goes out while `fclk` is low.
- R5: Pulse framing (`cfg_fsync`=1). `fclk` takes the level inverse of `cfg_pol` for the first bit clock of each frame and rests at `cfg_pol` for every other bit clock.
- R6: Data placement. In each half, bit position p (counted from 0 at the half start) carries sample bit 15-(p-`cfg_offset`) when `cfg_offset` ≤ p < `cfg_offset`+16. Every other position carries 0.
- R7: Stream handshake. `s_ready` is 1 for exactly one cycle per frame, in the cycle just before the frame's first falling bit-clock edge. The word taken then is the frame's sample pair: left in `s_data[31:16]`, right in `s_data[15:0]`.
- R8: Underrun. If `s_valid` is 0 while `s_ready` is 1, the frame sends zeros and `urun` is set. `urun` stays set until a cycle with `urun_clr`=1. If a new underrun occurs in that same cycle, the set wins.
- R9: Stop. After `tx_en` drops, the current frame completes and no further `s_ready` is given. From then on, `fclk` stays at its idle level and `sdata` stays 0.
- R10: Frame-start capture. `cfg_bitcnt`, `cfg_nonsym`, `cfg_offset`, `cfg_fsync` and `cfg_pol` are sampled at each frame start. A change in the middle of a frame leaves that frame unchanged and applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One pulse per bit-clock edge (half bit period) |
| cfg_bitcnt | input | CNT_W | Bit clocks per channel minus one |
| cfg_nonsym | input | 1 | Adds one bit clock to the right half |
| cfg_offset | input | OFF_W | Bit clocks from half start to the MSB |
| cfg_fsync | input | 1 | 0: level framing, 1: pulse framing |
| cfg_pol | input | 1 | Frame-clock polarity select |
| tx_en | input | 1 | Transmit enable |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word taken this cycle |
| s_data | input | 2*SMP_W | Left sample in the upper half, right sample in the lower half |
| urun_clr | input | 1 | Clears the underrun flag |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| sdata | output | 1 | Serial data |
| urun | output | 1 | Sticky underrun flag |

## Verification
The embedded properties check several rules on every cycle:
- the bit clock toggles on each tick;
- the frame clock and the data line hold still between falling edges;
- the position counter stays inside the current half;
- the captured configuration changes only at a frame start;
- STOP happens only at the end of a right half with the enable low;
- the underrun flag is sticky;
- the data line is quiet in IDLE.

Other behaviours need directed scenarios, because they depend on the whole serial waveform against a known configuration. These are the exact bit-by-bit content of each half (data offset, truncation when the half is short, the non-symmetric right half), the frame-clock shapes for both framing styles and both polarities, the orderly wind-down after the enable drops, and a configuration change that takes effect only one frame later.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    // Sequencer states: stopped, left half, right half.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } tx_state_e;

    // Resting level of the frame clock for a given framing style.
    function automatic logic fclk_rest(input logic fsync, input logic pol);
        return fsync ? pol : ~pol;
    endfunction

endpackage

// File: rtl/aud_tx_bclk.sv
module aud_tx_bclk (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    output logic bclk,
    output logic fall
);

    logic bclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        bclk_q <= 1'b0;
        else if (bit_tick) bclk_q <= ~bclk_q;
    end

    assign bclk = bclk_q;
    assign fall = bit_tick & bclk_q;

    a_r2_bclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (bclk_q != $past(bclk_q)));

endmodule

// File: rtl/aud_tx_seq.sv
module aud_tx_seq
    import aud_tx_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int OFF_W = 4,
    localparam int POS_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             tx_en,
    input  logic [CNT_W-1:0] cfg_bitcnt,
    input  logic             cfg_nonsym,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic             cfg_fsync,
    input  logic             cfg_pol,
    output tx_state_e        state_q,
    output tx_state_e        nxt_state,
    output logic [POS_W-1:0] nxt_pos,
    output logic             start,
    output logic [OFF_W-1:0] eff_offset,
    output logic             eff_fsync,
    output logic             eff_pol
);

    logic [POS_W-1:0] pos_q;
    logic [CNT_W-1:0] sh_bitcnt;
    logic             sh_nonsym;
    logic [OFF_W-1:0] sh_offset;
    logic             sh_fsync;
    logic             sh_pol;
    logic [POS_W-1:0] lim;
    logic             last;

    // Last position of the current half, using the frame's own settings.
    assign lim  = {1'b0, sh_bitcnt} + POS_W'(state_q == ST_RIGHT && sh_nonsym);
    assign last = (pos_q == lim);

    always_comb begin
        nxt_state = state_q;
        nxt_pos   = pos_q;
        start     = 1'b0;
        if (fall) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tx_en) begin            // GO
                        nxt_state = ST_LEFT;
                        nxt_pos   = '0;
                        start     = 1'b1;
                    end
                end
                ST_LEFT: begin
                    if (last) begin             // SWAP
                        nxt_state = ST_RIGHT;
                        nxt_pos   = '0;
                    end else begin
                        nxt_pos = pos_q + 1'b1;
                    end
                end
                ST_RIGHT: begin
                    if (last) begin
                        nxt_pos = '0;
                        if (tx_en) begin        // NEXT
                            nxt_state = ST_LEFT;
                            start     = 1'b1;
                        end else begin          // STOP
                            nxt_state = ST_IDLE;
                        end
                    end else begin
                        nxt_pos = pos_q + 1'b1;
                    end
                end
                default: begin
                    nxt_state = ST_IDLE;
                    nxt_pos   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= nxt_state;
            pos_q   <= nxt_pos;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_bitcnt <= '0;
            sh_nonsym <= 1'b0;
            sh_offset <= '0;
            sh_fsync  <= 1'b0;
            sh_pol    <= 1'b0;
        end else if (start) begin
            sh_bitcnt <= cfg_bitcnt;
            sh_nonsym <= cfg_nonsym;
            sh_offset <= cfg_offset;
            sh_fsync  <= cfg_fsync;
            sh_pol    <= cfg_pol;
        end
    end

    // Settings in force for the bit being produced at this edge.
    assign eff_offset = start ? cfg_offset : sh_offset;
    assign eff_fsync  = start ? cfg_fsync  : sh_fsync;
    assign eff_pol    = start ? cfg_pol    : sh_pol;

    a_r3_pos_in_half: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (pos_q <= {1'b0, sh_bitcnt} + POS_W'(1)));

    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(sh_bitcnt) && $stable(sh_offset) && $stable(sh_pol)));

    a_r9_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_RIGHT) |-> ($past(last) && !$past(tx_en)));

endmodule

// File: rtl/aud_tx_dpath.sv
module aud_tx_dpath
    import aud_tx_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int CNT_W = 8,
    parameter int OFF_W = 4,
    localparam int POS_W = CNT_W + 1,
    localparam int IDX_W = $clog2(SMP_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall,
    input  logic               start,
    input  tx_state_e          nxt_state,
    input  logic [POS_W-1:0]   nxt_pos,
    input  logic [OFF_W-1:0]   eff_offset,
    input  logic               eff_fsync,
    input  logic               eff_pol,
    input  logic               cfg_fsync,
    input  logic               cfg_pol,
    input  logic               s_valid,
    input  logic [2*SMP_W-1:0] s_data,
    input  logic               urun_clr,
    output logic               s_ready,
    output logic               fclk,
    output logic               sdata,
    output logic               urun
);

    logic [2*SMP_W-1:0] word_q;
    logic [2*SMP_W-1:0] word_e;
    logic [SMP_W-1:0]   half_w;
    logic [POS_W-1:0]   rel;
    logic               in_rng;
    logic [IDX_W-1:0]   bidx;
    logic               sd_d;
    logic               fc_d;
    logic               fclk_q;
    logic               sd_q;
    logic               uflag_q;

    assign s_ready = start;
    assign word_e  = start ? (s_valid ? s_data : '0) : word_q;
    assign half_w  = (nxt_state == ST_RIGHT) ? word_e[SMP_W-1:0] : word_e[2*SMP_W-1:SMP_W];

    // Bit selection by position relative to the data offset.
    assign rel    = nxt_pos - POS_W'(eff_offset);
    assign in_rng = (nxt_pos >= POS_W'(eff_offset)) && (rel < POS_W'(SMP_W));
    assign bidx   = IDX_W'(SMP_W - 1) - rel[IDX_W-1:0];
    assign sd_d   = (nxt_state != ST_IDLE) && in_rng && half_w[bidx];

    // Frame-clock level for the next bit.
    always_comb begin
        unique case (nxt_state)
            ST_IDLE:  fc_d = fclk_rest(cfg_fsync, cfg_pol);
            ST_LEFT:  fc_d = eff_fsync ? ((nxt_pos == '0) ? ~eff_pol : eff_pol) : eff_pol;
            ST_RIGHT: fc_d = eff_fsync ? eff_pol : ~eff_pol;
            default:  fc_d = fclk_rest(cfg_fsync, cfg_pol);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            fclk_q <= fclk_rest(cfg_fsync, cfg_pol);
            sd_q   <= 1'b0;
        end else if (fall) begin
            word_q <= word_e;
            fclk_q <= fc_d;
            sd_q   <= sd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  uflag_q <= 1'b0;
        else if (start && !s_valid)  uflag_q <= 1'b1;
        else if (urun_clr)           uflag_q <= 1'b0;
    end

    assign fclk  = fclk_q;
    assign sdata = sd_q;
    assign urun  = uflag_q;

    a_r2_fclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(fclk_q));

    a_r2_sdata_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(sd_q));

    a_r7_ready_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> fall);

    a_r8_urun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> uflag_q);

    a_r8_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uflag_q && !urun_clr) |=> uflag_q);

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int CNT_W = 8,
    parameter int OFF_W = 4,
    localparam int POS_W = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic [CNT_W-1:0]   cfg_bitcnt,
    input  logic               cfg_nonsym,
    input  logic [OFF_W-1:0]   cfg_offset,
    input  logic               cfg_fsync,
    input  logic               cfg_pol,
    input  logic               tx_en,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [2*SMP_W-1:0] s_data,
    input  logic               urun_clr,
    output logic               bclk,
    output logic               fclk,
    output logic               sdata,
    output logic               urun
);

    logic             fall;
    tx_state_e        state_q;
    tx_state_e        nxt_state;
    logic [POS_W-1:0] nxt_pos;
    logic             start;
    logic [OFF_W-1:0] eff_offset;
    logic             eff_fsync;
    logic             eff_pol;

    aud_tx_bclk u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .bclk     (bclk),
        .fall     (fall)
    );

    aud_tx_seq #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .tx_en      (tx_en),
        .cfg_bitcnt (cfg_bitcnt),
        .cfg_nonsym (cfg_nonsym),
        .cfg_offset (cfg_offset),
        .cfg_fsync  (cfg_fsync),
        .cfg_pol    (cfg_pol),
        .state_q    (state_q),
        .nxt_state  (nxt_state),
        .nxt_pos    (nxt_pos),
        .start      (start),
        .eff_offset (eff_offset),
        .eff_fsync  (eff_fsync),
        .eff_pol    (eff_pol)
    );

    aud_tx_dpath #(.SMP_W(SMP_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .start      (start),
        .nxt_state  (nxt_state),
        .nxt_pos    (nxt_pos),
        .eff_offset (eff_offset),
        .eff_fsync  (eff_fsync),
        .eff_pol    (eff_pol),
        .cfg_fsync  (cfg_fsync),
        .cfg_pol    (cfg_pol),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .urun_clr   (urun_clr),
        .s_ready    (s_ready),
        .fclk       (fclk),
        .sdata      (sdata),
        .urun       (urun)
    );

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sdata);

endmodule

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/1ps
module sim_aud_ser_tx;

    localparam int SW = 16;
    localparam int CW = 8;
    localparam int OW = 4;
    localparam int CAP = 2048;

    typedef struct {
        int bc;
        bit ns;
        int off;
        bit fs;
        bit pol;
    } tcfg_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic [CW-1:0] cfg_bitcnt = '0;
    logic          cfg_nonsym = 1'b0;
    logic [OW-1:0] cfg_offset = '0;
    logic          cfg_fsync = 1'b0;
    logic          cfg_pol = 1'b0;
    logic          tx_en = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [2*SW-1:0] s_data;
    logic          urun_clr = 1'b0;
    logic          bclk, fclk, sdata, urun;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int consumed = 0;
    int idx = 0;
    int nstart = 0;
    int starts[8];
    bit cap_f[CAP];
    bit cap_d[CAP];
    bit prev_b = 1'b0;

    aud_ser_tx #(.SMP_W(SW), .CNT_W(CW), .OFF_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .cfg_bitcnt(cfg_bitcnt), .cfg_nonsym(cfg_nonsym), .cfg_offset(cfg_offset),
        .cfg_fsync(cfg_fsync), .cfg_pol(cfg_pol), .tx_en(tx_en),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .urun_clr(urun_clr),
        .bclk(bclk), .fclk(fclk), .sdata(sdata), .urun(urun)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] smp(int f);
        return 32'h9A3C5E71 + 32'h13572469 * 32'(f);
    endfunction

    function automatic bit idle_lvl(tcfg_t c);
        return c.fs ? c.pol : !c.pol;
    endfunction

    always @(posedge clk) bit_tick <= rst_n ? ~bit_tick : 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            consumed <= 0;
            s_data   <= smp(0);
        end else if (s_ready && s_valid) begin
            consumed <= consumed + 1;
            s_data   <= smp(consumed + 1);
        end
    end

    // Monitor: records one entry per falling bit-clock edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_b = 1'b0;
        end else begin
            if (s_ready) begin
                if (nstart < 8) starts[nstart] = idx;
                nstart++;
            end
            if (prev_b && !bclk) begin
                if (idx < CAP) begin
                    cap_f[idx] = fclk;
                    cap_d[idx] = sdata;
                end
                idx++;
            end
            prev_b = bclk;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(tcfg_t c);
        cfg_bitcnt = CW'(c.bc);
        cfg_nonsym = c.ns;
        cfg_offset = OW'(c.off);
        cfg_fsync  = c.fs;
        cfg_pol    = c.pol;
    endtask

    task automatic do_reset(tcfg_t c, bit valid);
        @(posedge clk); #1;
        rst_n = 1'b0;
        tx_en = 1'b0;
        urun_clr = 1'b0;
        s_valid = valid;
        apply(c);
        repeat (4) @(posedge clk);
        #1;
        idx = 0;
        nstart = 0;
        rst_n = 1'b1;
    endtask

    // R1, R2: reset values and free-running bit clock while stopped.
    task automatic t_reset();
        tcfg_t c;
        c = '{bc: 31, ns: 0, off: 1, fs: 0, pol: 0};
        do_reset(c, 1'b1);
        #2;
        chk(bclk == 1'b0, "R1", "bclk after reset", bclk, 0);
        chk(fclk == 1'b1, "R1", "fclk idle after reset", fclk, 1);
        chk(sdata == 1'b0, "R1", "sdata after reset", sdata, 0);
        chk(s_ready == 1'b0 && urun == 1'b0, "R1", "ready/urun after reset", {s_ready, urun}, 0);
        repeat (40) @(posedge clk);
        #15;
        chk(idx == 10, "R2", "falling edges in 40 cycles", idx, 10);
        chk(nstart == 0 && sdata == 1'b0, "R9", "no frame while disabled", nstart, 0);
    endtask

    task automatic run_case(string name, int nfr, bit valid, tcfg_t c0, tcfg_t c1, string ftag);
        int total;
        int pos;
        int s_err, f_err, d_err, t_err;
        int s_act, s_exp, f_at, d_at, t_at;
        tcfg_t c;
        logic [31:0] w;
        logic [15:0] hw;
        bit ef, ed;
        int len;
        s_err = 0; f_err = 0; d_err = 0; t_err = 0;
        s_act = 0; s_exp = 0; f_at = 0; d_at = 0; t_at = 0;
        total = 0;
        for (int f = 0; f < nfr; f++) begin
            c = (f == 0) ? c0 : c1;
            total += 2 * (c.bc + 1) + int'(c.ns);
        end
        do_reset(c0, valid);
        @(posedge clk); #1;
        tx_en = 1'b1;
        while (nstart < 1) begin @(posedge clk); #1; end
        apply(c1);
        while (nstart < nfr) begin @(posedge clk); #1; end
        tx_en = 1'b0;
        while (idx < starts[0] + total + 12) begin @(posedge clk); #1; end

        pos = starts[0];
        for (int f = 0; f < nfr; f++) begin
            c = (f == 0) ? c0 : c1;
            if (f < 8 && starts[f] != pos && s_err == 0) begin
                s_err++; s_act = starts[f]; s_exp = pos;
            end
            w = valid ? smp(f) : 32'h0;
            for (int h = 0; h < 2; h++) begin
                len = c.bc + 1 + ((h == 1) ? int'(c.ns) : 0);
                hw = (h == 0) ? w[31:16] : w[15:0];
                for (int p = 0; p < len; p++) begin
                    if (c.fs) ef = (h == 0 && p == 0) ? !c.pol : c.pol;
                    else      ef = (h == 0) ? c.pol : !c.pol;
                    ed = (p >= c.off && p - c.off < 16) ? hw[15 - (p - c.off)] : 1'b0;
                    if (cap_f[pos] != ef) begin if (f_err == 0) f_at = pos; f_err++; end
                    if (cap_d[pos] != ed) begin if (d_err == 0) d_at = pos; d_err++; end
                    pos++;
                end
            end
        end
        for (int k = 0; k < 10; k++) begin
            if (cap_f[pos + k] != idle_lvl(c1) || cap_d[pos + k] != 1'b0) begin
                if (t_err == 0) t_at = pos + k;
                t_err++;
            end
        end
        $display("  case %s: %0d frames, %0d bit slots", name, nfr, total);
        chk(s_err == 0, "R3", {name, " frame start spacing"}, s_act, s_exp);
        chk(f_err == 0, ftag, {name, " frame clock mismatches (first slot in msg)"}, f_err, 0);
        if (f_err != 0) $display("  first frame clock mismatch at slot %0d", f_at);
        chk(d_err == 0, (ftag == "R10") ? "R10" : "R6", {name, " data mismatches"}, d_err, 0);
        if (d_err != 0) $display("  first data mismatch at slot %0d", d_at);
        chk(t_err == 0, "R9", {name, " idle after stop"}, t_err, 0);
        if (t_err != 0) $display("  first idle mismatch at slot %0d", t_at);
        chk(nstart == nfr, "R7", {name, " ready pulses"}, nstart, nfr);
        if (valid) chk(consumed == nfr, "R7", {name, " words taken"}, consumed, nfr);
        chk(urun == !valid, "R8", {name, " underrun flag"}, urun, int'(!valid));
    endtask

    // R8: flag stays until cleared, clear pulse removes it.
    task automatic t_urun_clear();
        repeat (30) @(posedge clk);
        #1;
        chk(urun == 1'b1, "R8", "underrun flag sticky", urun, 1);
        urun_clr = 1'b1;
        @(posedge clk); #1;
        urun_clr = 1'b0;
        chk(urun == 1'b0, "R8", "underrun flag cleared", urun, 0);
    endtask

    initial begin
        tcfg_t ca, cb, cc, cd;
        ca = '{bc: 31, ns: 0, off: 1, fs: 0, pol: 0};
        cb = '{bc: 19, ns: 1, off: 0, fs: 0, pol: 1};
        cc = '{bc: 15, ns: 0, off: 1, fs: 1, pol: 0};
        cd = '{bc: 31, ns: 0, off: 2, fs: 1, pol: 1};
        t_reset();
        run_case("level_pol0", 3, 1'b1, ca, ca, "R4");
        run_case("level_pol1_nonsym", 2, 1'b1, cb, cb, "R4");
        run_case("pulse_high_short", 2, 1'b1, cc, cc, "R5");
        run_case("pulse_low_off2", 2, 1'b1, cd, cd, "R5");
        run_case("underrun", 2, 1'b0, ca, ca, "R4");
        t_urun_clear();
        run_case("cfg_change", 3, 1'b1, ca, cb, "R10");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule